// File: doc/BRIEF.md
# Dual-Mode LCD Host Interface

This block is the microcontroller-facing front end of a character LCD controller. It works in one of two protocols, chosen by a static mode pin. The first is a strobed parallel bus that can be 8 or 4 bits wide. The second is a clocked serial link with an active-low chip select. All host pins are asynchronous to the controller clock, so they are resynchronised before any edge is acted on.

Each host access targets one of three registers: the data register, the instruction register or the expansion instruction register.

- A write becomes a single-cycle pulse toward the controller core. The pulse carries the target and the assembled byte.
- A read returns one of two values:
  - the core's read byte, for the data register;
  - the status byte, for either instruction register. The status byte has the busy flag at bit 7 and the 7-bit address below it.
- A completed data-register read raises a one-cycle read request, so the core can advance its address.

The block holds the bus-width state. An instruction-register write of the width-selection command changes that state.

Top module: `lcdh_host_if`

## Requirements
- R1: After a synchronous reset the block is idle. `wr_valid` is 0, `rd_req` is 0 and `db_oe` is all zeros. The parallel bus is 8 bits wide.
- R2: In parallel 8-bit mode, a strobe on `e_sck` with `rw_sdi`=0 gives exactly one `wr_valid` pulse after the strobe falls. The pulse carries `wr_target`={`rs1`,`rs0_csn`} and `wr_data`=`db_in` as it was when the strobe rose.
- R3: The target code is {rs1,rs0}. 2'b11 is the data register, 2'b10 the instruction register and 2'b00 the expansion instruction register. A write with code 2'b01 produces no `wr_valid` pulse.
- R4: In parallel 8-bit mode, a strobe with `rw_sdi`=1 drives all eight lines (`db_oe`=8'hFF) while the strobe is high. A data-register read returns `core_rd_data`. A read of either other register returns {`core_busy`,`core_addr`}. A data-register read gives one `rd_req` pulse after the strobe falls.
- R5: An instruction-register write whose data bits 7:5 equal 3'b001 sets the bus width. Bit 4 = 1 selects 8 bits and bit 4 = 0 selects 4 bits. The same write returns the nibble phase to "upper nibble next".
- R6: In 4-bit parallel mode, a byte is written with two strobes, upper nibble first, on `db_in[7:4]`. One `wr_valid` pulse follows the second strobe. `db_in[3:0]` has no effect on `wr_data`.
- R7: In 4-bit parallel mode, a read takes two strobes. The first presents the upper nibble on `db_out[7:4]` and the second presents the lower nibble. During each, `db_oe`=8'hF0.
- R8: In serial mode, a frame is 16 bits, MSB first, sampled on rising `e_sck` edges. The 8-bit header comes first: bit 7 is read (1) or write (0), bits 6:5 are the target code, and bits 4:0 are ignored. Eight data bits follow. A write frame pulses `wr_valid` after its 16th rising edge. Frames may follow one another under one chip-select window.
- R9: Serial transfers are accepted only while `rs0_csn` is low. Raising it clears the bit count, so a partial frame produces nothing and the next frame starts afresh.
- R10: In a serial read frame, the read value appears MSB first on `db_out[0]`. The bit changes on each falling `e_sck` edge, starting with the fall that follows the 8th rising edge, and `db_oe`=8'h01 meanwhile. A data-register read gives one `rd_req` pulse after the frame.
- R11: Outside a read, no line is driven (`db_oe`=0). In serial mode, lines 7:1 are never driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_serial | input | 1 | Static protocol select: 1 serial, 0 parallel |
| e_sck | input | 1 | Parallel enable strobe / serial shift clock |
| rw_sdi | input | 1 | Parallel read(1)/write(0) / serial data in |
| rs0_csn | input | 1 | Parallel target select bit 0 / serial chip select, active low |
| rs1 | input | 1 | Parallel target select bit 1 |
| db_in | input | 8 | Data lines as seen from the pads |
| db_out | output | 8 | Data driven toward the pads; bit 0 is serial out |
| db_oe | output | 8 | Per-line output enable |
| wr_valid | output | 1 | One-cycle write pulse to the core |
| wr_target | output | 2 | Target code of the write |
| wr_data | output | 8 | Assembled write byte |
| rd_req | output | 1 | One-cycle pulse after a data-register read |
| core_busy | input | 1 | Busy flag from the core |
| core_addr | input | 7 | Current address from the core |
| core_rd_data | input | 8 | Data-register read value from the core |

## Verification
The bench first drives the unmapped target code 01. A decoder that passed it through would emit a stray write, and the bench would see that pulse on a cycle where none was expected.

In 4-bit mode, the bench fills the unused low lines with junk and checks nibble order on both writes and reads. A swapped or mis-phased design would return bytes with their halves exchanged. The bench also switches width while running and looks for writes taken as single nibbles.

In serial mode, the bench aborts a frame part-way by raising chip select. A design that kept its bit count across that would misalign every later frame. The bench also checks that read bits stay stable until each falling edge, and that back-to-back frames under one select decode independently.

// File: rtl/lcdh_pkg.sv
`timescale 1ns/1ps
package lcdh_pkg;
  typedef enum logic [1:0] {
    TGT_EXP   = 2'b00,
    TGT_NONE  = 2'b01,
    TGT_INSTR = 2'b10,
    TGT_DATA  = 2'b11
  } tgt_e;

  localparam logic [2:0] WIDTH_CMD_TAG = 3'b001;
endpackage

// File: rtl/lcdh_sync.sv
`timescale 1ns/1ps
module lcdh_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lcdh_par.sv
`timescale 1ns/1ps
module lcdh_par
  import lcdh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              width4,
  input  logic              phase_clr,
  input  logic              e,
  input  logic              rw,
  input  logic              rs1,
  input  logic              rs0,
  input  logic [DATA_W-1:0] db,
  input  logic              core_busy,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_rd_data,
  output logic              wr_valid,
  output logic [1:0]        wr_target,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [DATA_W-1:0] db_out,
  output logic [DATA_W-1:0] db_oe
);
  localparam int NIB = DATA_W / 2;

  logic              e_q;
  logic              rise, fall;
  logic              phase;
  logic              cap_rw;
  logic [1:0]        cap_tgt;
  logic [DATA_W-1:0] cap_db;
  logic [DATA_W-1:0] rd_byte;
  logic [NIB-1:0]    hi_nib;
  logic [DATA_W-1:0] fresh;
  logic [DATA_W-1:0] src;

  assign rise  = e & ~e_q;
  assign fall  = ~e & e_q;
  assign fresh = ({rs1, rs0} == TGT_DATA) ? core_rd_data : {core_busy, core_addr};
  assign src   = (width4 && phase) ? rd_byte : fresh;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      e_q       <= 1'b0;
      phase     <= 1'b0;
      cap_rw    <= 1'b0;
      cap_tgt   <= TGT_EXP;
      cap_db    <= '0;
      rd_byte   <= '0;
      hi_nib    <= '0;
      wr_valid  <= 1'b0;
      wr_target <= TGT_EXP;
      wr_data   <= '0;
      rd_req    <= 1'b0;
      db_out    <= '0;
      db_oe     <= '0;
    end else begin
      e_q      <= e;
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (rise) begin
        cap_rw  <= rw;
        cap_tgt <= {rs1, rs0};
        cap_db  <= db;
        if (rw) begin
          if (!(width4 && phase)) rd_byte <= fresh;
          if (width4) begin
            db_out <= {(phase ? src[NIB-1:0] : src[DATA_W-1:NIB]), {NIB{1'b0}}};
            db_oe  <= {{NIB{1'b1}}, {NIB{1'b0}}};
          end else begin
            db_out <= src;
            db_oe  <= '1;
          end
        end
      end
      if (fall) begin
        db_oe <= '0;
        if (width4 && !phase) begin
          phase <= 1'b1;
          if (!cap_rw) hi_nib <= cap_db[DATA_W-1:NIB];
        end else begin
          phase <= 1'b0;
          if (!cap_rw) begin
            wr_valid  <= 1'b1;
            wr_target <= cap_tgt;
            wr_data   <= width4 ? {hi_nib, cap_db[DATA_W-1:NIB]} : cap_db;
          end else if (cap_tgt == TGT_DATA) begin
            rd_req <= 1'b1;
          end
        end
      end
      if (phase_clr) phase <= 1'b0;
    end
  end
endmodule

// File: rtl/lcdh_ser.sv
`timescale 1ns/1ps
module lcdh_ser
  import lcdh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sck,
  input  logic              sdi,
  input  logic              csn,
  input  logic              core_busy,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_rd_data,
  output logic              wr_valid,
  output logic [1:0]        wr_target,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic              so,
  output logic              so_oe
);
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(DATA_W);

  logic              sck_q;
  logic              rise, fall;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-2:0] shreg;
  logic [DATA_W-1:0] word;
  logic              hdr_rw;
  logic [1:0]        hdr_tgt;
  logic [DATA_W-1:0] out_sh;

  assign rise = sck & ~sck_q;
  assign fall = ~sck & sck_q;
  assign word = {shreg, sdi};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sck_q     <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      hdr_rw    <= 1'b0;
      hdr_tgt   <= TGT_EXP;
      out_sh    <= '0;
      wr_valid  <= 1'b0;
      wr_target <= TGT_EXP;
      wr_data   <= '0;
      rd_req    <= 1'b0;
      so        <= 1'b0;
      so_oe     <= 1'b0;
    end else begin
      sck_q    <= sck;
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (csn) begin
        cnt   <= '0;
        so_oe <= 1'b0;
      end else begin
        if (rise) begin
          shreg <= word[DATA_W-2:0];
          cnt   <= (cnt == FRAME_LAST) ? '0 : cnt + 1'b1;
          if (cnt == HDR_LAST) begin
            hdr_rw  <= word[DATA_W-1];
            hdr_tgt <= word[DATA_W-2 -: 2];
            if (word[DATA_W-1])
              out_sh <= (word[DATA_W-2 -: 2] == TGT_DATA) ? core_rd_data
                                                           : {core_busy, core_addr};
          end
          if (cnt == FRAME_LAST) begin
            if (!hdr_rw) begin
              wr_valid  <= 1'b1;
              wr_target <= hdr_tgt;
              wr_data   <= word;
            end else if (hdr_tgt == TGT_DATA) begin
              rd_req <= 1'b1;
            end
          end
        end
        if (fall) begin
          if (hdr_rw && cnt >= DATA_FIRST) begin
            so     <= out_sh[DATA_W-1];
            out_sh <= {out_sh[DATA_W-2:0], 1'b0};
            so_oe  <= 1'b1;
          end else begin
            so_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lcdh_host_if.sv
`timescale 1ns/1ps
module lcdh_host_if
  import lcdh_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_serial,
  input  logic              e_sck,
  input  logic              rw_sdi,
  input  logic              rs0_csn,
  input  logic              rs1,
  input  logic [DATA_W-1:0] db_in,
  output logic [DATA_W-1:0] db_out,
  output logic [DATA_W-1:0] db_oe,
  output logic              wr_valid,
  output logic [1:0]        wr_target,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  input  logic              core_busy,
  input  logic [DATA_W-2:0] core_addr,
  input  logic [DATA_W-1:0] core_rd_data
);
  localparam int ADDR_W = DATA_W - 1;
  localparam int PIN_W  = DATA_W + 4;

  logic [PIN_W-1:0]  pins_s;
  logic              e_s, rw_s, rs0_s, rs1_s;
  logic [DATA_W-1:0] db_s;

  lcdh_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({e_sck, rw_sdi, rs0_csn, rs1, db_in}),
    .q(pins_s)
  );
  assign {e_s, rw_s, rs0_s, rs1_s, db_s} = pins_s;

  logic              width4;
  logic              phase_clr;
  logic              par_wr, ser_wr, par_rd, ser_rd;
  logic [1:0]        par_tgt, ser_tgt;
  logic [DATA_W-1:0] par_data, ser_data;
  logic [DATA_W-1:0] par_out, par_oe;
  logic              ser_so, ser_oe;

  lcdh_par #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_par (
    .clk(clk), .rst(rst), .en(!mode_serial),
    .width4(width4), .phase_clr(phase_clr),
    .e(e_s), .rw(rw_s), .rs1(rs1_s), .rs0(rs0_s), .db(db_s),
    .core_busy(core_busy), .core_addr(core_addr), .core_rd_data(core_rd_data),
    .wr_valid(par_wr), .wr_target(par_tgt), .wr_data(par_data),
    .rd_req(par_rd), .db_out(par_out), .db_oe(par_oe)
  );

  lcdh_ser #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ser (
    .clk(clk), .rst(rst), .en(mode_serial),
    .sck(e_s), .sdi(rw_s), .csn(rs0_s),
    .core_busy(core_busy), .core_addr(core_addr), .core_rd_data(core_rd_data),
    .wr_valid(ser_wr), .wr_target(ser_tgt), .wr_data(ser_data),
    .rd_req(ser_rd), .so(ser_so), .so_oe(ser_oe)
  );

  logic              sel_wr;
  logic [1:0]        sel_tgt;
  logic [DATA_W-1:0] sel_data;

  assign sel_wr    = mode_serial ? ser_wr   : par_wr;
  assign sel_tgt   = mode_serial ? ser_tgt  : par_tgt;
  assign sel_data  = mode_serial ? ser_data : par_data;
  assign phase_clr = sel_wr && (sel_tgt == TGT_INSTR) &&
                     (sel_data[DATA_W-1 -: 3] == WIDTH_CMD_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      width4    <= 1'b0;
      wr_valid  <= 1'b0;
      wr_target <= TGT_EXP;
      wr_data   <= '0;
      rd_req    <= 1'b0;
    end else begin
      wr_valid  <= sel_wr && (sel_tgt != TGT_NONE);
      wr_target <= sel_tgt;
      wr_data   <= sel_data;
      rd_req    <= mode_serial ? ser_rd : par_rd;
      if (phase_clr) width4 <= ~sel_data[DATA_W-4];
    end
  end

  assign db_out = mode_serial ? {{(DATA_W-1){1'b0}}, ser_so} : par_out;
  assign db_oe  = mode_serial ? {{(DATA_W-1){1'b0}}, ser_oe} : par_oe;
endmodule

// File: rtl/lcdh_host_if_chk.sv
`timescale 1ns/1ps
module lcdh_host_if_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_serial,
  input logic              wr_valid,
  input logic [1:0]        wr_target,
  input logic              rd_req,
  input logic [DATA_W-1:0] db_oe
);
  localparam logic [DATA_W-1:0] UPPER_OE = {{(DATA_W/2){1'b1}}, {(DATA_W/2){1'b0}}};

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_valid && !rd_req && db_oe == '0));

  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  // R3
  no_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_target != 2'b01);

  // R4
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R7
  par_oe_shape_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_serial |-> (db_oe == '0 || db_oe == UPPER_OE || db_oe == '1));

  // R11
  ser_oe_shape_chk: assert property (@(posedge clk) disable iff (rst)
    mode_serial |-> (db_oe[DATA_W-1:1] == '0));

  // R11
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> db_oe == '0);
endmodule

bind lcdh_host_if lcdh_host_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mode_serial(mode_serial), .wr_valid(wr_valid),
  .wr_target(wr_target), .rd_req(rd_req), .db_oe(db_oe)
);

// File: tb/lcdh_host_if_tb.sv
`timescale 1ns/1ps
module lcdh_host_if_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_serial = 1'b0;
  logic       e_sck = 1'b0, rw_sdi = 1'b0, rs0_csn = 1'b1, rs1 = 1'b1;
  logic [7:0] db_in = 8'hFF;
  logic [7:0] db_out, db_oe, wr_data, core_rd_data = 8'h00;
  logic [1:0] wr_target;
  logic       wr_valid, rd_req, core_busy = 1'b0;
  logic [6:0] core_addr = 7'h00;

  always #2.5 clk = ~clk;

  lcdh_host_if u_dut (
    .clk(clk), .rst(rst), .mode_serial(mode_serial), .e_sck(e_sck),
    .rw_sdi(rw_sdi), .rs0_csn(rs0_csn), .rs1(rs1), .db_in(db_in),
    .db_out(db_out), .db_oe(db_oe), .wr_valid(wr_valid), .wr_target(wr_target),
    .wr_data(wr_data), .rd_req(rd_req), .core_busy(core_busy),
    .core_addr(core_addr), .core_rd_data(core_rd_data)
  );

  int         checks = 0;
  int         fails  = 0;
  logic [9:0] exp_wr[$];
  int         exp_rd = 0;
  logic       width4_m = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard: every clock, any write or read-request pulse must be expected.
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid) begin
        if (exp_wr.size() == 0) chk("R2/R3 unexpected write", {22'd0, wr_target, wr_data}, 32'h0);
        else chk("R2/R3 write", {22'd0, wr_target, wr_data}, {22'd0, exp_wr.pop_front()});
      end
      if (rd_req) begin
        if (exp_rd == 0) chk("R4 unexpected rd_req", 1, 0);
        else begin exp_rd--; checks++; end
      end
    end
  end

  task automatic par_strobe(input logic rw, input logic [1:0] rs, input logic [7:0] d,
                            output logic [7:0] o_db, output logic [7:0] o_oe);
    rw_sdi = rw; rs1 = rs[1]; rs0_csn = rs[0]; db_in = d;
    tick(4);
    e_sck = 1'b1;
    tick(8);
    o_db = db_out; o_oe = db_oe;
    e_sck = 1'b0;
    tick(8);
  endtask

  task automatic par_write(input logic [1:0] rs, input logic [7:0] b);
    logic [7:0] od, oo;
    if (width4_m) begin
      par_strobe(1'b0, rs, {b[7:4], 4'h5}, od, oo);
      if (rs != 2'b01) exp_wr.push_back({rs, b});
      par_strobe(1'b0, rs, {b[3:0], 4'hA}, od, oo);
    end else begin
      if (rs != 2'b01) exp_wr.push_back({rs, b});
      par_strobe(1'b0, rs, b, od, oo);
    end
    if (rs == 2'b10 && b[7:5] == 3'b001) width4_m = ~b[4];
    tick(4);
    chk(width4_m ? "R6 writes drained" : "R2 writes drained", exp_wr.size(), 0);
  endtask

  task automatic par_read(input logic [1:0] rs, input logic [7:0] expb);
    logic [7:0] od, oo;
    if (width4_m) begin
      par_strobe(1'b1, rs, 8'h00, od, oo);
      chk("R7 upper nibble", od[7:4], expb[7:4]);
      chk("R7 oe", oo, 8'hF0);
      if (rs == 2'b11) exp_rd++;
      par_strobe(1'b1, rs, 8'h00, od, oo);
      chk("R7 lower nibble", od[7:4], expb[3:0]);
      chk("R7 oe", oo, 8'hF0);
    end else begin
      if (rs == 2'b11) exp_rd++;
      par_strobe(1'b1, rs, 8'h00, od, oo);
      chk("R4 read byte", od, expb);
      chk("R4 oe", oo, 8'hFF);
    end
    tick(4);
    chk("R11 released", db_oe, 8'h00);
    chk("R4 rd_req count", exp_rd, 0);
  endtask

  task automatic ser_bit(input logic b, output logic o_so, output logic [7:0] o_oe);
    rw_sdi = b;
    tick(4);
    o_so = db_out[0]; o_oe = db_oe;
    e_sck = 1'b1;
    tick(8);
    e_sck = 1'b0;
    tick(8);
  endtask

  task automatic ser_frame(input logic rw, input logic [1:0] rs, input logic [7:0] d,
                           input logic [7:0] expb, input logic keep_cs);
    logic [7:0] hdr, oo;
    logic       so;
    hdr = {rw, rs, 5'b10110};
    rs0_csn = 1'b0;
    tick(4);
    for (int i = 0; i < 8; i++) ser_bit(hdr[7-i], so, oo);
    if (!rw && rs != 2'b01) exp_wr.push_back({rs, d});
    if (rw && rs == 2'b11) exp_rd++;
    for (int i = 0; i < 8; i++) begin
      ser_bit(rw ? 1'b1 : d[7-i], so, oo);
      if (rw) begin
        chk("R10 serial bit", so, expb[7-i]);
        chk("R10 serial oe", oo, 8'h01);
      end
    end
    if (!keep_cs) rs0_csn = 1'b1;
    tick(6);
    chk("R11 serial released", db_oe, 8'h00);
    chk("R8 frame drained", exp_wr.size() + exp_rd, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(1);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 db_oe", db_oe, 8'h00);
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic so;
    logic [7:0] oo;
    do_reset();

    // R2, R3: 8-bit writes to each target, unmapped code ignored
    par_write(2'b11, 8'h41);
    par_write(2'b10, 8'h0C);
    par_write(2'b00, 8'h5A);
    par_write(2'b01, 8'h77);

    // R4: reads in 8-bit mode (R1: default width is 8 bits)
    core_rd_data = 8'hC3; core_busy = 1'b1; core_addr = 7'h25;
    par_read(2'b11, 8'hC3);
    par_read(2'b10, 8'hA5);
    par_read(2'b00, 8'hA5);
    core_busy = 1'b0; core_addr = 7'h4F;
    par_read(2'b10, 8'h4F);

    // R5: width command to 4-bit
    par_write(2'b10, 8'h28);
    // R6: 4-bit writes, junk on low lines
    par_write(2'b11, 8'h9E);
    par_write(2'b00, 8'h31);
    par_write(2'b10, 8'h0F);
    par_write(2'b01, 8'hE4);
    // R7: 4-bit reads
    core_rd_data = 8'h6B;
    par_read(2'b11, 8'h6B);
    core_busy = 1'b1; core_addr = 7'h12;
    par_read(2'b10, 8'h92);
    // R5: back to 8-bit, sent as nibbles
    par_write(2'b10, 8'h38);
    par_write(2'b11, 8'hD2);
    core_rd_data = 8'h17;
    par_read(2'b11, 8'h17);

    // Serial mode
    mode_serial = 1'b1;
    e_sck = 1'b0; rs0_csn = 1'b1; db_in = 8'hFF;
    do_reset();
    // R8, R3: serial writes
    ser_frame(1'b0, 2'b11, 8'hA7, 8'h00, 1'b0);
    ser_frame(1'b0, 2'b10, 8'h01, 8'h00, 1'b0);
    ser_frame(1'b0, 2'b00, 8'hFE, 8'h00, 1'b0);
    ser_frame(1'b0, 2'b01, 8'h33, 8'h00, 1'b0);
    // R9: aborted frame then a full one
    rs0_csn = 1'b0;
    tick(4);
    for (int i = 0; i < 5; i++) ser_bit(i[0], so, oo);
    rs0_csn = 1'b1;
    tick(10);
    chk("R9 partial frame silent", exp_wr.size(), 0);
    ser_frame(1'b0, 2'b11, 8'h5C, 8'h00, 1'b0);
    // R10: serial reads
    core_rd_data = 8'h3D;
    ser_frame(1'b1, 2'b11, 8'h00, 8'h3D, 1'b0);
    core_busy = 1'b1; core_addr = 7'h7F;
    ser_frame(1'b1, 2'b10, 8'h00, 8'hFF, 1'b0);
    core_busy = 1'b0; core_addr = 7'h00;
    ser_frame(1'b1, 2'b00, 8'h00, 8'h00, 1'b0);
    // R8: back-to-back frames under one chip select
    ser_frame(1'b0, 2'b11, 8'hC8, 8'h00, 1'b1);
    core_rd_data = 8'hB6;
    ser_frame(1'b1, 2'b11, 8'h00, 8'hB6, 1'b0);

    tick(10);
    chk("R8 nothing left", exp_wr.size() + exp_rd, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule